// File: doc/BRIEF.md
# Successive-Approximation Conversion Engine with Window Limit Check

This block is the digital half of an 8-bit successive-approximation converter. After a start request it puts a trial code on an output that feeds an external DAC. It reads the result of an external comparator and settles one bit per step, from the most significant bit down. When the last bit is settled it pulses `done` and presents the code. A prescaler divides the incoming peripheral clock by a programmable factor from 1 to 8, and each bit decision takes one divided period.

While the conversion runs, the engine checks the value against a window set by a high limit and a low limit. As soon as the upper four bits are settled, they are compared with the upper four bits of both limits. If they already lie outside the window, a sticky limit flag is raised at that point, halfway through the conversion. Otherwise the complete 8-bit code is compared with the full limits when the conversion ends. A conversion raises the flag at most once. The check runs only while its enable input is high. Software clears the flag with a one-cycle clear input.

Top module: `sar_window_core`

## Requirements
- R1: Each bit decision takes `div_sel`+1 clock cycles, so `done` is high exactly 8*(`div_sel`+1) cycles after the rising edge that accepts `start`.
- R2: In the cycle after a start is accepted, `trial` is 8'h80. Bits are then resolved from bit 7 down to bit 0. At each decision the trial bit under test is kept when `cmp_in` is 1 and cleared when `cmp_in` is 0, and the next lower bit is set.
- R3: `done` is high for exactly one cycle. In that same cycle `result` holds the converted code, which is the largest code for which the comparator reported 1 (input value >= trial).
- R4: When the resolved upper nibble is greater than `lim_hi[7:4]` or less than `lim_lo[7:4]` and `lim_ie` is 1, `lim_flag` becomes 1 exactly 4*(`div_sel`+1) cycles after the start edge. Before that cycle it is 0.
- R5: When the upper nibble lies within the window, the full 8-bit code is compared with `lim_hi` and `lim_lo` at the end. A code above `lim_hi` or below `lim_lo` sets `lim_flag` in the cycle in which `done` is high.
- R6: A value equal to a limit, whether as a nibble or as the full code, counts as inside and raises no flag.
- R7: While `lim_ie` is 0 the limit check has no effect, and `lim_flag` does not rise.
- R8: If the nibble check has raised the flag, the final 8-bit check does not raise it again in the same conversion. A flag cleared between the two checks stays 0.
- R9: `flag_clr` clears `lim_flag` on the next edge. If the clear and a flag set fall on the same edge, the set wins.
- R10: A `start` that arrives while a conversion is in progress is ignored. The running conversion keeps its timing and its result.
- R11: After reset `busy`, `done`, `lim_flag`, `result` and `trial` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Conversion request, taken when idle |
| cmp_in | input | 1 | Comparator result: 1 when the input value is at or above the trial code |
| div_sel | input | 3 | Step clock divide factor minus one |
| lim_hi | input | 8 | Upper window limit |
| lim_lo | input | 8 | Lower window limit |
| lim_ie | input | 1 | Enable for the window check |
| flag_clr | input | 1 | Clears the limit flag |
| trial | output | 8 | Trial code for the external DAC |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle end-of-conversion pulse |
| result | output | 8 | Last converted code |
| lim_flag | output | 1 | Sticky window-violation flag |

## Verification
The final full-width window compare and a software clear of the limit flag can land on the same rising edge. The bench provokes this by asserting `flag_clr` in exactly the cycle whose closing edge raises `done`, using a code whose nibble is inside the window and whose full value is outside it. It judges the outcome by reading `lim_flag` one cycle later, where it must be 1. A second run asserts the clear on the edge just after an early nibble hit and expects the flag to stay 0 through `done`, which shows that the end-of-conversion check was suppressed.

// File: rtl/sar_pkg.sv
package sar_pkg;
  // Converter sequencing states
  typedef enum logic {
    SAR_IDLE = 1'b0,
    SAR_RUN  = 1'b1
  } sar_state_e;
endpackage

// File: rtl/sar_prescale.sv
// Step-enable generator: one tick every (div_sel + 1) clocks while running.
module sar_prescale #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)          cnt <= '0;
    else if (cnt == div_sel)  cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == div_sel);
endmodule

// File: rtl/sar_step.sv
// Bit-by-bit approximation register, MSB first.
module sar_step #(
  parameter int DATA_W  = 8,
  parameter int NIB_POS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              tick,
  input  logic              cmp_in,
  output logic              busy,
  output logic              accept,
  output logic [DATA_W-1:0] trial,
  output logic [DATA_W-1:0] decided,
  output logic              nib_evt,
  output logic              last_evt,
  output logic [DATA_W-1:0] result,
  output logic              done
);
  import sar_pkg::*;

  localparam logic [DATA_W-1:0] TOP_BIT = {1'b1, {(DATA_W-1){1'b0}}};

  sar_state_e        state;
  logic [DATA_W-1:0] mask;   // one-hot pointer at the bit under test

  assign busy     = (state == SAR_RUN);
  assign accept   = start && (state == SAR_IDLE);
  assign decided  = cmp_in ? trial : (trial & ~mask);
  assign nib_evt  = tick && mask[NIB_POS];
  assign last_evt = tick && mask[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SAR_IDLE;
      mask   <= '0;
      trial  <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        SAR_IDLE: begin
          if (start) begin
            state <= SAR_RUN;
            mask  <= TOP_BIT;
            trial <= TOP_BIT;
          end
        end
        SAR_RUN: begin
          if (tick) begin
            if (mask[0]) begin
              state  <= SAR_IDLE;
              mask   <= '0;
              trial  <= decided;
              result <= decided;
              done   <= 1'b1;
            end else begin
              mask  <= mask >> 1;
              trial <= decided | (mask >> 1);
            end
          end
        end
        default: state <= SAR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_window.sv
// Two-phase window compare: nibble check at mid-conversion, full check at end.
module sar_window #(
  parameter int DATA_W = 8,
  parameter int HALF_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              nib_evt,
  input  logic              last_evt,
  input  logic              ie,
  input  logic              flag_clr,
  input  logic [DATA_W-1:0] code,
  input  logic [DATA_W-1:0] hi,
  input  logic [DATA_W-1:0] lo,
  output logic              flag
);
  logic [HALF_W-1:0] code_n, hi_n, lo_n;
  logic nib_out, full_out, set_early, set_full, early_hit;

  assign code_n = code[DATA_W-1 -: HALF_W];
  assign hi_n   = hi[DATA_W-1 -: HALF_W];
  assign lo_n   = lo[DATA_W-1 -: HALF_W];

  // Equal to a limit counts as inside
  assign nib_out  = (code_n > hi_n) || (code_n < lo_n);
  assign full_out = (code > hi) || (code < lo);

  assign set_early = ie && nib_evt && nib_out;
  assign set_full  = ie && last_evt && !early_hit && full_out;

  always_ff @(posedge clk) begin
    if (rst)            early_hit <= 1'b0;
    else if (accept)    early_hit <= 1'b0;
    else if (set_early) early_hit <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                       flag <= 1'b0;
    else if (set_early || set_full) flag <= 1'b1;
    else if (flag_clr)             flag <= 1'b0;
  end
endmodule

// File: rtl/sar_window_core.sv
module sar_window_core #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cmp_in,
  input  logic [DIV_W-1:0]  div_sel,
  input  logic [DATA_W-1:0] lim_hi,
  input  logic [DATA_W-1:0] lim_lo,
  input  logic              lim_ie,
  input  logic              flag_clr,
  output logic [DATA_W-1:0] trial,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              lim_flag
);
  localparam int HALF_W = DATA_W / 2;

  logic              tick, accept, nib_evt, last_evt;
  logic [DATA_W-1:0] decided;

  sar_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .run     (busy),
    .div_sel (div_sel),
    .tick    (tick)
  );

  sar_step #(.DATA_W(DATA_W), .NIB_POS(HALF_W)) u_step (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .tick     (tick),
    .cmp_in   (cmp_in),
    .busy     (busy),
    .accept   (accept),
    .trial    (trial),
    .decided  (decided),
    .nib_evt  (nib_evt),
    .last_evt (last_evt),
    .result   (result),
    .done     (done)
  );

  sar_window #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_win (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .nib_evt  (nib_evt),
    .last_evt (last_evt),
    .ie       (lim_ie),
    .flag_clr (flag_clr),
    .code     (decided),
    .hi       (lim_hi),
    .lo       (lim_lo),
    .flag     (lim_flag)
  );
endmodule

// File: rtl/sar_window_chk.sv
module sar_window_chk #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [DIV_W-1:0]  div_sel,
  input logic              lim_ie,
  input logic              flag_clr,
  input logic [DATA_W-1:0] trial,
  input logic              busy,
  input logic              done,
  input logic              lim_flag
);
  localparam logic [DATA_W-1:0] TOP_BIT = {1'b1, {(DATA_W-1){1'b0}}};

  logic [15:0] cyc;
  always_ff @(posedge clk) begin
    if (rst)                 cyc <= '0;
    else if (start && !busy) cyc <= '0;
    else if (busy)           cyc <= cyc + 1'b1;
  end

  // R1
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (cyc == DATA_W * (32'(div_sel) + 1)));

  // R2
  first_trial_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (trial == TOP_BIT));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R7
  no_flag_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !lim_ie |=> !$rose(lim_flag));

  // R9
  idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !busy) |=> !lim_flag);
endmodule

bind sar_window_core sar_window_chk #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .div_sel  (div_sel),
  .lim_ie   (lim_ie),
  .flag_clr (flag_clr),
  .trial    (trial),
  .busy     (busy),
  .done     (done),
  .lim_flag (lim_flag)
);

// File: tb/sim_sar_window_core.sv
`timescale 1ns/1ps
module sim_sar_window_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [2:0] div_sel = '0;
  logic [7:0] lim_hi = '0, lim_lo = '0;
  logic       lim_ie = 1'b0, flag_clr = 1'b0;
  logic [7:0] vin = '0;
  logic [7:0] trial, result;
  logic       busy, done, lim_flag, cmp_in;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  // Ideal comparator model for the analog input value
  assign cmp_in = (vin >= trial);

  sar_window_core u0 (
    .clk(clk), .rst(rst), .start(start), .cmp_in(cmp_in), .div_sel(div_sel),
    .lim_hi(lim_hi), .lim_lo(lim_lo), .lim_ie(lim_ie), .flag_clr(flag_clr),
    .trial(trial), .busy(busy), .done(done), .result(result), .lim_flag(lim_flag)
  );

  // {vin, hi, lo, ie, div}
  localparam int NV = 9;
  localparam logic [27:0] VEC [0:NV-1] = '{
    {8'h5A, 8'hC0, 8'h20, 1'b1, 3'd0},  // inside
    {8'hE7, 8'hC0, 8'h20, 1'b1, 3'd1},  // nibble above
    {8'h10, 8'hC0, 8'h20, 1'b1, 3'd2},  // nibble below
    {8'hC5, 8'hC0, 8'h20, 1'b1, 3'd3},  // full above only
    {8'hC0, 8'hC0, 8'h20, 1'b1, 3'd7},  // equal high
    {8'h20, 8'hC0, 8'h20, 1'b1, 3'd0},  // equal low
    {8'hFF, 8'hC0, 8'h20, 1'b0, 3'd4},  // check disabled
    {8'h00, 8'hFF, 8'h00, 1'b1, 3'd5},  // widest window
    {8'h23, 8'hC0, 8'h25, 1'b1, 3'd6}   // full below only
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic nib_bad(input logic [7:0] v, h, l);
    return (v[7:4] > h[7:4]) || (v[7:4] < l[7:4]);
  endfunction

  function automatic logic full_bad(input logic [7:0] v, h, l);
    return (v > h) || (v < l);
  endfunction

  // One conversion; clr_at / again_at select the cycle index (k) at which
  // flag_clr or a second start is driven for one cycle.
  task automatic run_conv(input logic [7:0] v, input logic [2:0] d,
                          input logic [7:0] h, input logic [7:0] l, input logic ie,
                          input int clr_at, input int again_at,
                          output int lat, output logic [7:0] tr0,
                          output logic f_pre, output logic f_nib,
                          output logic [7:0] res, output logic f_end,
                          output logic dn_next);
    int k;
    int n;
    n = int'(d) + 1;
    @(negedge clk);
    vin = v; div_sel = d; lim_hi = h; lim_lo = l; lim_ie = ie; flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 1;
    tr0 = trial;
    f_pre = 1'b0; f_nib = 1'b0;
    while (1) begin
      if (k - 1 == 4 * n - 1) f_pre = lim_flag;
      if (k - 1 == 4 * n)     f_nib = lim_flag;
      if (done || k > 200) break;
      flag_clr = (k == clr_at);
      start    = (k == again_at);
      @(negedge clk);
      k++;
    end
    flag_clr = 1'b0; start = 1'b0;
    lat = k - 1;
    res = result;
    f_end = lim_flag;
    @(negedge clk);
    dn_next = done;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    logic [7:0] tr0, res;
    logic f_pre, f_nib, f_end, dn_next;
    logic [7:0] v, h, l;
    logic ie;
    logic [2:0] d;

    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 busy", busy, 0);
    chk("R11 done", done, 0);
    chk("R11 lim_flag", lim_flag, 0);
    chk("R11 result", result, 0);
    chk("R11 trial", trial, 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      {v, h, l, ie, d} = VEC[i];
      run_conv(v, d, h, l, ie, -1, -1, lat, tr0, f_pre, f_nib, res, f_end, dn_next);
      chk("R2 first trial", tr0, 8'h80);
      chk("R1 latency", lat, 8 * (int'(d) + 1));
      chk("R3 result", res, v);
      chk("R3 done width", dn_next, 0);
      chk("R4 flag before nibble", f_pre, 0);
      chk("R4 R7 flag at nibble", f_nib, ie && nib_bad(v, h, l));
      chk("R5 R6 R7 flag at end", f_end, ie && (nib_bad(v, h, l) || full_bad(v, h, l)));
    end

    // R9: clear while idle drops the flag
    run_conv(8'hE7, 3'd0, 8'hC0, 8'h20, 1'b1, -1, -1, lat, tr0, f_pre, f_nib, res, f_end, dn_next);
    chk("R9 flag set before clear", lim_flag, 1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk("R9 idle clear", lim_flag, 0);

    // R8: early hit cleared on the edge after it; no second raise at end
    run_conv(8'hE7, 3'd1, 8'hC0, 8'h20, 1'b1, 4 * 2 + 1, -1, lat, tr0, f_pre, f_nib, res, f_end, dn_next);
    chk("R8 early raised", f_nib, 1);
    chk("R8 no second raise", f_end, 0);

    // R9: clear on the same edge as the final set; set wins
    run_conv(8'hC5, 3'd1, 8'hC0, 8'h20, 1'b1, 8 * 2, -1, lat, tr0, f_pre, f_nib, res, f_end, dn_next);
    chk("R9 set beats clear", f_end, 1);
    chk("R9 nibble inside", f_nib, 0);

    // R10: start during a conversion is ignored
    run_conv(8'h6B, 3'd1, 8'hFF, 8'h00, 1'b1, -1, 3, lat, tr0, f_pre, f_nib, res, f_end, dn_next);
    chk("R10 latency kept", lat, 16);
    chk("R10 result kept", res, 8'h6B);
    chk("R10 single done", dn_next, 0);
    chk("R10 still idle", busy, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule